// File: doc/BRIEF.md
# Machine State Register with Interrupt, Privilege and Power Gating

This block holds the processor's 32-bit machine state word. Its individual enable bits gate the raw interrupt request lines. They also decide whether decoded instruction classes raise exceptions, and whether the doze, nap and sleep requests from the hardware configuration register reach the power-management logic. Software loads the word through a write port and reads it back on `stateOut`.

Interrupt entry saves the whole word into a shadow register and clears the wait-enable bit in the same edge, so the power outputs drop while the handler runs. Return from interrupt copies the shadow word back in one cycle, which puts wait enable and the power outputs back where they were. The gating and exception outputs are combinational from the current word and the present strobes. The word itself changes only on a clock edge.

Bits are named with the big-endian numbering 32..63, where 63 is the least significant bit. Big-endian bit n is bit 63-n of `stateOut` and `wrData`.

Top module: `msr_gate`

## Requirements
- R1: After reset the word and its shadow copy hold RESET_VAL restricted to the defined bits (zero by default), and with a zero word every gated interrupt, power output and exception output is low.
- R2: A write with no interrupt entry or return in the same cycle loads `wrData` on the next edge. Only the defined bits are kept: user cache-lock enable 37 (vector bit 26), vector-unit enable 38 (bit 25), wait enable 45 (bit 18), critical enable 46 (bit 17), external enable 48 (bit 15), problem state 49 (bit 14), machine-check enable 51 (bit 12), user branch-buffer-lock enable 53 (bit 10). All other bits read as zero, so writing all ones reads back 0x0606D400.
- R3: `irqGated[0]` (critical input) and `irqGated[1]` (watchdog) follow the raw lines while critical enable is 1 and are 0 while it is 0.
- R4: `irqGated[2]` (external), `[3]` (decrementer), `[4]` (fixed-interval timer) and `[5]` (performance monitor) pass only while external enable is 1.
- R5: `irqGated[6]` (machine check) passes only while machine-check enable is 1.
- R6: `pmOut[k]` equals `pmReq[k]` while wait enable is 1 and is 0 otherwise (index 0 doze, 1 nap, 2 sleep).
- R7: On `intEntry` the shadow register takes the current word and the word loses its wait-enable bit on the next edge, all other bits unchanged. Entry wins over a same-cycle write or return.
- R8: On `intReturn` without entry the word takes the shadow value on the next edge. Return wins over a same-cycle write.
- R9: `excPriv` is 1 when `opPriv` is asserted with problem state 1. With problem state 0 no instruction raises it.
- R10: With problem state 1 and user cache-lock enable 0, `opDLock` or `opILock` raises `excStorage`. `synDataLock` mirrors `opDLock` and `synInstLock` mirrors `opILock`. Otherwise all three stay 0.
- R11: With problem state 1 and user branch-buffer-lock enable 0, `opBranchLock` raises `excPriv`.
- R12: With vector-unit enable 0, `opUpperReg` raises `excVecUnavail`. With it set, the exception stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Software write strobe |
| wrData | input | 32 | Write data for the state word |
| stateOut | output | 32 | Current state word |
| intEntry | input | 1 | Interrupt entry pulse |
| intReturn | input | 1 | Return-from-interrupt pulse |
| irqRaw | input | 7 | Raw requests: crit, wdog, ext, dec, fit, perf, mchk (bit 0 to 6) |
| irqGated | output | 7 | Requests after enable gating, same order |
| pmReq | input | 3 | Doze, nap, sleep request levels |
| pmOut | output | 3 | Gated doze, nap, sleep |
| opPriv | input | 1 | Privileged instruction strobe |
| opDLock | input | 1 | Data-cache lock instruction strobe |
| opILock | input | 1 | Instruction-cache lock instruction strobe |
| opBranchLock | input | 1 | Branch-buffer lock instruction strobe |
| opUpperReg | input | 1 | Upper-half register access strobe |
| excPriv | output | 1 | Privileged-instruction exception |
| excStorage | output | 1 | Data-storage exception for cache locking |
| synDataLock | output | 1 | Syndrome: data-cache lock cause |
| synInstLock | output | 1 | Syndrome: instruction-cache lock cause |
| excVecUnavail | output | 1 | Vector-unit-unavailable exception |

## Verification
The bench builds the block with the default RESET_VAL of zero. The first cycles therefore exercise the fully masked supervisor state before any write. The fixed 32-bit layout lets one all-ones write reach every reserved position at once, and a directed sequence places entry, return and writes in the same cycle to check the priority order. Randomised traffic then nests entry and return around writes, so wait enable is seen to drop and come back with the power requests held high.

// File: rtl/msr_gate_pkg.sv
package msr_gate_pkg;
  localparam int REG_W   = 32;
  localparam int BE_LAST = 63;

  localparam int POS_UCLE = BE_LAST - 37;
  localparam int POS_SPE  = BE_LAST - 38;
  localparam int POS_WE   = BE_LAST - 45;
  localparam int POS_CE   = BE_LAST - 46;
  localparam int POS_EE   = BE_LAST - 48;
  localparam int POS_PR   = BE_LAST - 49;
  localparam int POS_ME   = BE_LAST - 51;
  localparam int POS_UBLE = BE_LAST - 53;

  localparam logic [REG_W-1:0] DEF_MASK =
      (REG_W'(1) << POS_UCLE) | (REG_W'(1) << POS_SPE) |
      (REG_W'(1) << POS_WE)   | (REG_W'(1) << POS_CE)  |
      (REG_W'(1) << POS_EE)   | (REG_W'(1) << POS_PR)  |
      (REG_W'(1) << POS_ME)   | (REG_W'(1) << POS_UBLE);

  localparam int NUM_IRQ   = 7;
  localparam int IRQ_CRIT  = 0;
  localparam int IRQ_WDOG  = 1;
  localparam int IRQ_MCHK  = 6;
  localparam int NUM_PM    = 3;

  typedef struct packed {
    logic saveCur;
    logic clearWait;
    logic restoreSaved;
    logic loadWrite;
  } msrCtlT;
endpackage

// File: rtl/msr_ctl.sv
module msr_ctl
  import msr_gate_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   wrEn,
  input  logic   intEntry,
  input  logic   intReturn,
  input  logic   bitPr,
  input  logic   bitUcle,
  input  logic   bitUble,
  input  logic   bitSpe,
  input  logic   opPriv,
  input  logic   opDLock,
  input  logic   opILock,
  input  logic   opBranchLock,
  input  logic   opUpperReg,
  output msrCtlT ctl,
  output logic   excPriv,
  output logic   excStorage,
  output logic   synDataLock,
  output logic   synInstLock,
  output logic   excVecUnavail
);
  logic cacheLockDenied;
  logic branchLockDenied;

  always_comb begin
    ctl.saveCur      = intEntry;
    ctl.clearWait    = intEntry;
    ctl.restoreSaved = intReturn && !intEntry;
    ctl.loadWrite    = wrEn && !intEntry && !intReturn;
  end

  always_comb begin
    cacheLockDenied  = bitPr && !bitUcle;
    branchLockDenied = bitPr && !bitUble && opBranchLock;
    excPriv          = (bitPr && opPriv) || branchLockDenied;
    excStorage       = cacheLockDenied && (opDLock || opILock);
    synDataLock      = cacheLockDenied && opDLock;
    synInstLock      = cacheLockDenied && opILock;
    excVecUnavail    = !bitSpe && opUpperReg;
  end

  AST_ENTRY_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    intEntry |-> !ctl.loadWrite && !ctl.restoreSaved); // R7
  AST_RETURN_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    intReturn |-> !ctl.loadWrite); // R8
  AST_SUPERVISOR_NO_PRIV: assert property (@(posedge clk) disable iff (!rstN)
    !bitPr |-> !excPriv); // R9
  AST_SUPERVISOR_NO_STORAGE: assert property (@(posedge clk) disable iff (!rstN)
    !bitPr |-> !excStorage && !synDataLock && !synInstLock); // R10
  AST_VEC_ENABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    bitSpe |-> !excVecUnavail); // R12
endmodule

// File: rtl/msr_dp.sv
module msr_dp
  import msr_gate_pkg::*;
#(
  parameter logic [REG_W-1:0] RESET_VAL = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  msrCtlT             ctl,
  input  logic [REG_W-1:0]   wrData,
  input  logic [NUM_IRQ-1:0] irqRaw,
  input  logic [NUM_PM-1:0]  pmReq,
  output logic [REG_W-1:0]   stateQ,
  output logic [NUM_IRQ-1:0] irqGated,
  output logic [NUM_PM-1:0]  pmOut
);
  localparam logic [REG_W-1:0] RESET_CLEAN = RESET_VAL & DEF_MASK;
  localparam logic [REG_W-1:0] WAIT_BIT    = REG_W'(1) << POS_WE;

  logic [REG_W-1:0] saveQ;
  logic [REG_W-1:0] stateNext;
  logic [REG_W-1:0] saveNext;

  always_comb begin
    stateNext = stateQ;
    saveNext  = saveQ;
    if (ctl.saveCur) begin
      saveNext = stateQ;
    end
    if (ctl.clearWait) begin
      stateNext = stateQ & ~WAIT_BIT;
    end else if (ctl.restoreSaved) begin
      stateNext = saveQ;
    end else if (ctl.loadWrite) begin
      stateNext = wrData & DEF_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= RESET_CLEAN;
      saveQ  <= RESET_CLEAN;
    end else begin
      stateQ <= stateNext;
      saveQ  <= saveNext;
    end
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : gIrq
    localparam int EN_POS = (g <= IRQ_WDOG) ? POS_CE :
                            ((g == IRQ_MCHK) ? POS_ME : POS_EE);
    assign irqGated[g] = irqRaw[g] & stateQ[EN_POS];
  end

  for (genvar p = 0; p < NUM_PM; p++) begin : gPm
    assign pmOut[p] = pmReq[p] & stateQ[POS_WE];
  end

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ & ~DEF_MASK) == '0); // R2
  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadWrite |=> stateQ == ($past(wrData) & DEF_MASK)); // R2
  AST_WAIT_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clearWait |=> !stateQ[POS_WE]); // R7
  AST_SAVE_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.saveCur |=> saveQ == $past(stateQ)); // R7
  AST_RESTORE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.restoreSaved |=> stateQ == $past(saveQ)); // R8
  AST_PM_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !stateQ[POS_WE] |-> pmOut == '0); // R6
  AST_CRIT_MASK: assert property (@(posedge clk) disable iff (!rstN)
    !stateQ[POS_CE] |-> irqGated[IRQ_WDOG:IRQ_CRIT] == '0); // R3
  AST_EXT_MASK: assert property (@(posedge clk) disable iff (!rstN)
    !stateQ[POS_EE] |-> irqGated[5:2] == '0); // R4
  AST_MCHK_MASK: assert property (@(posedge clk) disable iff (!rstN)
    !stateQ[POS_ME] |-> !irqGated[IRQ_MCHK]); // R5
endmodule

// File: rtl/msr_gate.sv
module msr_gate
  import msr_gate_pkg::*;
#(
  parameter logic [31:0] RESET_VAL = 32'h0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] stateOut,
  input  logic        intEntry,
  input  logic        intReturn,
  input  logic [6:0]  irqRaw,
  output logic [6:0]  irqGated,
  input  logic [2:0]  pmReq,
  output logic [2:0]  pmOut,
  input  logic        opPriv,
  input  logic        opDLock,
  input  logic        opILock,
  input  logic        opBranchLock,
  input  logic        opUpperReg,
  output logic        excPriv,
  output logic        excStorage,
  output logic        synDataLock,
  output logic        synInstLock,
  output logic        excVecUnavail
);
  msrCtlT           ctl;
  logic [REG_W-1:0] stateQ;

  msr_ctl u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .wrEn         (wrEn),
    .intEntry     (intEntry),
    .intReturn    (intReturn),
    .bitPr        (stateQ[POS_PR]),
    .bitUcle      (stateQ[POS_UCLE]),
    .bitUble      (stateQ[POS_UBLE]),
    .bitSpe       (stateQ[POS_SPE]),
    .opPriv       (opPriv),
    .opDLock      (opDLock),
    .opILock      (opILock),
    .opBranchLock (opBranchLock),
    .opUpperReg   (opUpperReg),
    .ctl          (ctl),
    .excPriv      (excPriv),
    .excStorage   (excStorage),
    .synDataLock  (synDataLock),
    .synInstLock  (synInstLock),
    .excVecUnavail(excVecUnavail)
  );

  msr_dp #(.RESET_VAL(RESET_VAL)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .wrData  (wrData),
    .irqRaw  (irqRaw),
    .pmReq   (pmReq),
    .stateQ  (stateQ),
    .irqGated(irqGated),
    .pmOut   (pmOut)
  );

  assign stateOut = stateQ;
endmodule

// File: tb/msr_gate_tb_top.sv
module msr_gate_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] stateOut;
  logic        intEntry = 1'b0;
  logic        intReturn = 1'b0;
  logic [6:0]  irqRaw = '0;
  logic [6:0]  irqGated;
  logic [2:0]  pmReq = '0;
  logic [2:0]  pmOut;
  logic        opPriv = 1'b0, opDLock = 1'b0, opILock = 1'b0;
  logic        opBranchLock = 1'b0, opUpperReg = 1'b0;
  logic        excPriv, excStorage, synDataLock, synInstLock, excVecUnavail;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [31:0] mState = '0;
  logic [31:0] mSave  = '0;
  localparam logic [31:0] M_MASK = 32'h0606_D400;

  always #2 clk = ~clk;

  msr_gate dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .stateOut(stateOut),
    .intEntry(intEntry), .intReturn(intReturn), .irqRaw(irqRaw), .irqGated(irqGated),
    .pmReq(pmReq), .pmOut(pmOut), .opPriv(opPriv), .opDLock(opDLock), .opILock(opILock),
    .opBranchLock(opBranchLock), .opUpperReg(opUpperReg), .excPriv(excPriv),
    .excStorage(excStorage), .synDataLock(synDataLock), .synInstLock(synInstLock),
    .excVecUnavail(excVecUnavail)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare all outputs against the model, inputs already settled
  task automatic compareAll();
    logic ce, ee, me, we, pr, ucle, uble, spe, denyCache;
    logic [6:0] gExp;
    ce = mState[17]; ee = mState[15]; me = mState[12]; we = mState[18];
    pr = mState[14]; ucle = mState[26]; uble = mState[10]; spe = mState[25];
    gExp[0] = irqRaw[0] & ce;
    gExp[1] = irqRaw[1] & ce;
    for (int i = 2; i < 6; i++) gExp[i] = irqRaw[i] & ee;
    gExp[6] = irqRaw[6] & me;
    denyCache = pr & ~ucle;
    chk("R2 R7 R8 state word", stateOut, mState);
    chk("R3 crit/wdog gating", {30'd0, irqGated[1:0]}, {30'd0, gExp[1:0]});
    chk("R4 external group gating", {28'd0, irqGated[5:2]}, {28'd0, gExp[5:2]});
    chk("R5 machine check gating", {31'd0, irqGated[6]}, {31'd0, gExp[6]});
    chk("R6 power outputs", {29'd0, pmOut}, {29'd0, pmReq & {3{we}}});
    chk("R9 R11 privileged exception", {31'd0, excPriv},
        {31'd0, (pr & opPriv) | (pr & ~uble & opBranchLock)});
    chk("R10 storage exception and syndrome", {29'd0, excStorage, synDataLock, synInstLock},
        {29'd0, denyCache & (opDLock | opILock), denyCache & opDLock, denyCache & opILock});
    chk("R12 vector unavailable", {31'd0, excVecUnavail}, {31'd0, ~spe & opUpperReg});
  endtask

  // one cycle: drive after negedge, check, advance model to post-edge value
  task automatic cycle(input logic we_, input logic [31:0] d, input logic ent, input logic ret);
    @(negedge clk);
    wrEn = we_; wrData = d; intEntry = ent; intReturn = ret;
    irqRaw = 7'($urandom); pmReq = 3'($urandom);
    opPriv = 1'($urandom); opDLock = 1'($urandom); opILock = 1'($urandom);
    opBranchLock = 1'($urandom); opUpperReg = 1'($urandom);
    #1;
    compareAll();
    if (ent) begin
      mSave = mState;
      mState[18] = 1'b0;
    end else if (ret) begin
      mState = mSave;
    end else if (we_) begin
      mState = d & M_MASK;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state, everything masked
    #1;
    chk("R1 reset word", stateOut, 32'h0);
    chk("R1 reset outputs", {19'd0, irqGated, pmOut, excPriv, excStorage, excVecUnavail},
        32'h0);
    // R2: all ones write keeps only defined bits
    cycle(1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0);
    cycle(1'b0, 32'h0, 1'b0, 1'b0);
    chk("R2 all-ones readback", stateOut, 32'h0606_D400);
    // R7: entry with same-cycle write, write lost, wait cleared
    cycle(1'b1, 32'h0, 1'b1, 1'b0);
    cycle(1'b0, 32'h0, 1'b0, 1'b0);
    chk("R7 entry beats write", stateOut, 32'h0602_D400);
    // R8: return with same-cycle write restores saved word
    cycle(1'b1, 32'h0, 1'b0, 1'b1);
    cycle(1'b0, 32'h0, 1'b0, 1'b0);
    chk("R8 return beats write", stateOut, 32'h0606_D400);
    // R7: entry and return together, entry wins
    cycle(1'b0, 32'h0, 1'b1, 1'b1);
    cycle(1'b0, 32'h0, 1'b0, 1'b0);
    chk("R7 entry beats return", stateOut, 32'h0602_D400);
    cycle(1'b0, 32'h0, 1'b0, 1'b1);
    // user mode with locks denied, supervisor, mixed patterns
    cycle(1'b1, 32'h0004_4000, 1'b0, 1'b0);
    repeat (8) cycle(1'b0, 32'h0, 1'b0, 1'b0);
    cycle(1'b1, 32'h0602_9400, 1'b0, 1'b0);
    repeat (8) cycle(1'b0, 32'h0, 1'b0, 1'b0);
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      cycle(r < 30, $urandom, (r >= 30 && r < 40) || r == 99, (r >= 40 && r < 50) || r == 98);
    end
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule